// File: doc/BRIEF.md
# UART Receive FIFO with Trigger Interrupt, RTS Hysteresis and Character Timeout

This block buffers received characters between a UART deserializer and the host. The deserializer pushes bytes one per cycle, and the host pops them from a show-ahead head. A sixteen-entry store holds the bytes while the FIFO is enabled. When the enable input is low, the store shrinks to a single holding register. A two-bit select picks the receive trigger level. A trigger interrupt is high while the fill count is at or above that level.

Flow control uses a two-state machine. In `RTS_ON` the remote sender is allowed to transmit. The machine moves to `RTS_OFF` when the fill count climbs to the negate threshold for the selected level. It moves back to `RTS_ON` once the count has drained to the lower reassert threshold. A second machine watches for bytes stranded below the trigger level:
- `TMO_IDLE` goes to `TMO_ARMED` when the count is non-zero and below the level.
- `TMO_ARMED` counts character ticks and returns to `TMO_IDLE` if the condition goes away.
- `TMO_ARMED` goes to `TMO_FIRED` after four ticks with no push or pop.
- `TMO_FIRED` returns to `TMO_IDLE` on a pop.

Both machines return to their first state when the FIFO is cleared. A clear happens on the clear input or on any change of the enable input.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, and on the cycle after `fifo_clr` is high, `rx_level` is 0, `rts` is 1, `overrun` is 0, `irq_trig` is 0 and `irq_tmo` is 0.
- R2: With `fifo_en`=1 up to 16 bytes are held. They appear on `host_byte` in push order, and `rx_level` follows every accepted push and pop on the next edge.
- R3: A push that finds the store full is discarded and sets `overrun`. `overrun` stays set until a cycle with `ovr_ack`=1.
- R4: With `fifo_en`=0 the store holds one byte: a second push is an overrun, and `rts` is 0 exactly while that byte is held. Any change of `fifo_en` empties the store as `fifo_clr` does.
- R5: `trig_sel` encodes the level as 00=1, 01=4, 10=8, 11=14. `irq_trig` is 1 exactly when `rx_level` is at or above the level (level 1 when `fifo_en`=0).
- R6: `rts` falls on the edge where `rx_level` reaches 4, 8, 12 or 14 for `trig_sel` 00, 01, 10, 11.
- R7: Once low, `rts` stays low until `rx_level` falls to 1, 4, 8 or 10 for `trig_sel` 00, 01, 10, 11, and rises on that edge.
- R8: `irq_tmo` rises on the fourth `char_tick` after the last push or pop while `rx_level` is between 1 and level-1. It never rises when the level is already reached.
- R9: Any accepted push or pop restarts the tick count, and a pop clears `irq_tmo` on the next edge.
- R10: A pop while the store is empty is ignored and leaves `rx_level` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = sixteen-entry mode, 0 = single holding register |
| fifo_clr | input | 1 | Empties the store and resets flow control |
| trig_sel | input | 2 | Trigger level select (00=1, 01=4, 10=8, 11=14) |
| rx_push | input | 1 | Byte from the deserializer is valid |
| rx_byte | input | 8 | Byte from the deserializer |
| host_pop | input | 1 | Host removes the head byte |
| host_byte | output | 8 | Head byte (show-ahead) |
| rx_level | output | 5 | Bytes held |
| char_tick | input | 1 | One pulse per character time |
| ovr_ack | input | 1 | Clears the sticky overrun flag |
| overrun | output | 1 | Sticky: a byte was lost to a full store |
| irq_trig | output | 1 | Fill count at or above trigger level |
| irq_tmo | output | 1 | Character timeout below trigger level |
| rts | output | 1 | 1 = remote may send, 0 = hold off |

## Verification
For every trigger select, the bench fills the store one byte at a time up to full and one push beyond, then drains it completely. Each step is compared with a model of the threshold arithmetic. The asymmetric fill-and-drain path separates the negate edge of the hysteresis from the reassert edge, and it exposes any mix-up between the level encodings. Timeouts are tried at every fill count below each level, which separates the fourth tick from the third and shows the armed range boundaries. A restart sequence shows that a push resets the count. A single-register pass and a mid-fill clear cover the mode switch and the return of flow control.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;

    typedef enum logic { RTS_ON, RTS_OFF } rts_state_e;

    typedef enum logic [1:0] { TMO_IDLE, TMO_ARMED, TMO_FIRED } tmo_state_e;

    typedef logic [7:0] lvl_t;

    // Fill level at which the trigger interrupt is raised.
    function automatic lvl_t trig_level(input logic [1:0] sel);
        unique case (sel)
            2'b00: return 8'd1;
            2'b01: return 8'd4;
            2'b10: return 8'd8;
            default: return 8'd14;
        endcase
    endfunction

    // Fill level at which the sender is told to stop.
    function automatic lvl_t stop_level(input logic [1:0] sel);
        unique case (sel)
            2'b00: return 8'd4;
            2'b01: return 8'd8;
            2'b10: return 8'd12;
            default: return 8'd14;
        endcase
    endfunction

    // Fill level at or below which the sender may resume.
    function automatic lvl_t go_level(input logic [1:0] sel);
        unique case (sel)
            2'b00: return 8'd1;
            2'b01: return 8'd4;
            2'b10: return 8'd8;
            default: return 8'd10;
        endcase
    endfunction

endpackage

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         one_slot,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    input  logic                         ovr_clr,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [$clog2(DEPTH+1)-1:0]   count_nxt,
    output logic [W-1:0]                 head_data,
    output logic                         push_ok,
    output logic                         pop_ok,
    output logic                         overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          lost;

    assign cap       = one_slot ? CW'(1) : CW'(DEPTH);
    assign pop_ok    = pop && (count != '0) && !flush;
    assign push_ok   = push && !flush && ((count < cap) || pop_ok);
    assign lost      = push && !flush && !push_ok;
    assign head_data = mem[rd_ptr];

    always_comb begin
        count_nxt = count;
        if (flush) begin
            count_nxt = '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   count_nxt = count + CW'(1);
                2'b01:   count_nxt = count - CW'(1);
                default: count_nxt = count;
            endcase
        end
    end

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            count <= count_nxt;
            if (flush) begin
                wr_ptr  <= '0;
                rd_ptr  <= '0;
                overrun <= 1'b0;
            end else begin
                if (push_ok) wr_ptr <= step_ptr(wr_ptr);
                if (pop_ok)  rd_ptr <= step_ptr(rd_ptr);
                if (lost)         overrun <= 1'b1;
                else if (ovr_clr) overrun <= 1'b0;
            end
        end
    end

    // R2: the count never exceeds the store depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3: overrun holds until acknowledged or flushed
    a_r3_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr && !flush) |=> overrun);

    // R4: single-register mode never holds more than one byte
    a_r4_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (one_slot && $past(one_slot)) |-> (count <= CW'(1)));

    // R10: popping an empty store changes nothing
    a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && !push) |=> (count == '0));

endmodule

// File: rtl/rxf_flow.sv
`timescale 1ns/1ps
module rxf_flow
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         one_slot,
    input  logic [1:0]                   trig_sel,
    input  logic [$clog2(DEPTH+1)-1:0]   count,
    input  logic [$clog2(DEPTH+1)-1:0]   count_nxt,
    output logic                         rts,
    output logic                         irq_trig
);
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0] lvl, stop_thr, go_thr;
    rts_state_e    st_q, st_d;

    always_comb begin
        if (one_slot) begin
            lvl      = CW'(1);
            stop_thr = CW'(1);
            go_thr   = CW'(0);
        end else begin
            lvl      = CW'(trig_level(trig_sel));
            stop_thr = CW'(stop_level(trig_sel));
            go_thr   = CW'(go_level(trig_sel));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RTS_ON;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = RTS_ON;
        end else begin
            unique case (st_q)
                RTS_ON:  if (count_nxt >= stop_thr) st_d = RTS_OFF;
                RTS_OFF: if (count_nxt <= go_thr)   st_d = RTS_ON;
            endcase
        end
    end

    always_comb begin
        rts      = (st_q == RTS_ON);
        irq_trig = (count >= lvl);
    end

    // R6: at or above the stop threshold the sender is held off
    a_r6_rts_negated: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(trig_sel) && $stable(one_slot) && count >= stop_thr) |-> !rts);

    // R7: at or below the resume threshold the sender is allowed
    a_r7_rts_reasserted: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(trig_sel) && $stable(one_slot) && count <= go_thr) |-> rts);

endmodule

// File: rtl/rxf_charto.sv
`timescale 1ns/1ps
module rxf_charto
    import rxf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         one_slot,
    input  logic [1:0]                   trig_sel,
    input  logic [$clog2(DEPTH+1)-1:0]   count_nxt,
    input  logic                         activity,
    input  logic                         pop_ok,
    input  logic                         char_tick,
    output logic                         irq_tmo
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int TW = $clog2(TMO_CHARS+1);

    tmo_state_e    st_q, st_d;
    logic [TW-1:0] tk_q, tk_d;
    logic [CW-1:0] lvl;
    logic          below;

    assign lvl   = CW'(trig_level(trig_sel));
    assign below = !one_slot && (count_nxt != '0) && (count_nxt < lvl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TMO_IDLE;
            tk_q <= '0;
        end else begin
            st_q <= st_d;
            tk_q <= tk_d;
        end
    end

    always_comb begin
        st_d = st_q;
        tk_d = tk_q;
        unique case (st_q)
            TMO_IDLE: begin
                tk_d = '0;
                if (!flush && below) st_d = TMO_ARMED;
            end
            TMO_ARMED: begin
                if (flush || !below) begin
                    st_d = TMO_IDLE;
                    tk_d = '0;
                end else if (activity) begin
                    tk_d = '0;
                end else if (char_tick) begin
                    if (tk_q == TW'(TMO_CHARS-1)) begin
                        st_d = TMO_FIRED;
                        tk_d = '0;
                    end else begin
                        tk_d = tk_q + TW'(1);
                    end
                end
            end
            TMO_FIRED: begin
                tk_d = '0;
                if (flush || pop_ok) st_d = TMO_IDLE;
            end
            default: begin
                st_d = TMO_IDLE;
                tk_d = '0;
            end
        endcase
    end

    always_comb begin
        irq_tmo = (st_q == TMO_FIRED);
    end

    // R9: a pop clears the timeout interrupt
    a_r9_tmo_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tmo && pop_ok) |=> !irq_tmo);

    // R9: a push or pop never fires the timeout on the following edge
    a_r9_activity_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (activity && !irq_tmo) |=> !irq_tmo);

endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo #(
    parameter int W         = 8,
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_en,
    input  logic                         fifo_clr,
    input  logic [1:0]                   trig_sel,
    input  logic                         rx_push,
    input  logic [W-1:0]                 rx_byte,
    input  logic                         host_pop,
    output logic [W-1:0]                 host_byte,
    output logic [$clog2(DEPTH+1)-1:0]   rx_level,
    input  logic                         char_tick,
    input  logic                         ovr_ack,
    output logic                         overrun,
    output logic                         irq_trig,
    output logic                         irq_tmo,
    output logic                         rts
);
    localparam int CW = $clog2(DEPTH+1);

    logic          en_q, flush, one_slot;
    logic          push_ok, pop_ok;
    logic [CW-1:0] count_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    assign flush    = fifo_clr || (fifo_en != en_q);
    assign one_slot = !fifo_en;

    rxf_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .one_slot  (one_slot),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (host_pop),
        .ovr_clr   (ovr_ack),
        .count     (rx_level),
        .count_nxt (count_nxt),
        .head_data (host_byte),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .overrun   (overrun)
    );

    rxf_flow #(.DEPTH(DEPTH)) u_flow (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .one_slot  (one_slot),
        .trig_sel  (trig_sel),
        .count     (rx_level),
        .count_nxt (count_nxt),
        .rts       (rts),
        .irq_trig  (irq_trig)
    );

    rxf_charto #(.DEPTH(DEPTH), .TMO_CHARS(TMO_CHARS)) u_charto (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .one_slot  (one_slot),
        .trig_sel  (trig_sel),
        .count_nxt (count_nxt),
        .activity  (push_ok || pop_ok),
        .pop_ok    (pop_ok),
        .char_tick (char_tick),
        .irq_tmo   (irq_tmo)
    );

    // R1: a clear leaves an empty store with the sender allowed
    a_r1_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (rx_level == '0 && rts && !overrun && !irq_tmo));

    // R8: a timeout is only ever reported with data present
    a_r8_tmo_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tmo |-> (rx_level != '0));

endmodule

// File: tb/uart_rx_fifo_test.sv
`timescale 1ns/1ps
module uart_rx_fifo_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_en, fifo_clr, rx_push, host_pop, char_tick, ovr_ack;
    logic [1:0] trig_sel;
    logic [7:0] rx_byte, host_byte;
    logic [4:0] rx_level;
    logic       overrun, irq_trig, irq_tmo, rts;

    always #4 clk = ~clk;

    uart_rx_fifo uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
        .trig_sel(trig_sel), .rx_push(rx_push), .rx_byte(rx_byte),
        .host_pop(host_pop), .host_byte(host_byte), .rx_level(rx_level),
        .char_tick(char_tick), .ovr_ack(ovr_ack), .overrun(overrun),
        .irq_trig(irq_trig), .irq_tmo(irq_tmo), .rts(rts)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int         mcnt, mh, mt, msel;
    bit         mrts, movr, msingle;
    logic [7:0] mq [16];

    function automatic int lvl_of(int s, bit single);
        if (single) return 1;
        return (s == 0) ? 1 : (s == 3) ? 14 : 4 * s;
    endfunction
    function automatic int stop_of(int s, bit single);
        if (single) return 1;
        return (s == 3) ? 14 : 4 * (s + 1);
    endfunction
    function automatic int go_of(int s, bit single);
        if (single) return 0;
        return (s == 0) ? 1 : (s == 3) ? 10 : 4 * s;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input bit p, input logic [7:0] d, input bit q,
                        input bit t, input bit c, input bit a);
        rx_push = p; rx_byte = d; host_pop = q; char_tick = t;
        fifo_clr = c; ovr_ack = a;
        @(negedge clk);
        rx_push = 0; host_pop = 0; char_tick = 0; fifo_clr = 0; ovr_ack = 0;
    endtask

    task automatic upd_rts();
        if (mrts && mcnt >= stop_of(msel, msingle)) mrts = 0;
        else if (!mrts && mcnt <= go_of(msel, msingle)) mrts = 1;
    endtask

    task automatic m_flush();
        mcnt = 0; mh = 0; mt = 0; movr = 0; mrts = 1;
    endtask

    task automatic do_push(input logic [7:0] d);
        step(1, d, 0, 0, 0, 0);
        if (mcnt < (msingle ? 1 : 16)) begin
            mq[mt] = d; mt = (mt + 1) % 16; mcnt++;
        end else begin
            movr = 1;
        end
        upd_rts();
    endtask

    task automatic do_pop();
        step(0, 8'h00, 1, 0, 0, 0);
        if (mcnt > 0) begin
            mh = (mh + 1) % 16; mcnt--;
        end
        upd_rts();
    endtask

    task automatic do_clr();
        step(0, 8'h00, 0, 0, 1, 0);
        m_flush();
    endtask

    task automatic set_sel(input int s);
        trig_sel = 2'(s); msel = s;
        @(negedge clk);
    endtask

    task automatic set_mode(input bit en);
        fifo_en = en; msingle = !en;
        @(negedge clk);
        m_flush();
    endtask

    task automatic chk_all(input string req);
        chk(req, "rx_level", int'(rx_level), mcnt);
        chk(req, "rts", int'(rts), int'(mrts));
        chk(req, "irq_trig", int'(irq_trig), int'(mcnt >= lvl_of(msel, msingle)));
        chk(req, "overrun", int'(overrun), int'(movr));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; fifo_en = 1; fifo_clr = 0; trig_sel = 0; rx_push = 0;
        rx_byte = 0; host_pop = 0; char_tick = 0; ovr_ack = 0;
        msel = 0; msingle = 0; m_flush();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk_all("R1");
        chk("R1", "irq_tmo", int'(irq_tmo), 0);

        // R2 R3 R5 R6 R7 R10: full fill and drain for every trigger select
        for (int s = 0; s < 4; s++) begin
            set_sel(s);
            do_clr();
            chk_all("R1");
            for (int i = 0; i < 16; i++) begin
                do_push(8'((s * 16 + i) ^ 8'hA5));
                chk_all("R6");
                chk("R5", "irq_trig", int'(irq_trig), int'(mcnt >= lvl_of(s, 0)));
            end
            do_push(8'h5A);
            chk("R3", "overrun", int'(overrun), 1);
            chk("R3", "rx_level", int'(rx_level), 16);
            step(0, 8'h00, 0, 0, 0, 0);
            chk("R3", "overrun held", int'(overrun), 1);
            step(0, 8'h00, 0, 0, 0, 1);
            movr = 0;
            chk("R3", "overrun ack", int'(overrun), 0);
            for (int i = 0; i < 16; i++) begin
                chk("R2", "host_byte", int'(host_byte), int'(mq[mh]));
                do_pop();
                chk_all("R7");
            end
            do_pop();
            chk("R10", "rx_level", int'(rx_level), 0);
            chk_all("R10");
        end

        // R8 R9: timeout at every fill count below the level
        for (int s = 0; s < 4; s++) begin
            set_sel(s);
            if (lvl_of(s, 0) == 1) begin
                do_clr();
                do_push(8'h11);
                for (int k = 0; k < 5; k++) step(0, 8'h00, 0, 1, 0, 0);
                chk("R8", "irq_tmo at level", int'(irq_tmo), 0);
            end
            for (int n = 1; n < lvl_of(s, 0); n++) begin
                do_clr();
                for (int i = 0; i < n; i++) do_push(8'(n + i));
                for (int k = 1; k <= 4; k++) begin
                    step(0, 8'h00, 0, 1, 0, 0);
                    chk("R8", "irq_tmo tick", int'(irq_tmo), int'(k == 4));
                end
                do_pop();
                chk("R9", "irq_tmo after pop", int'(irq_tmo), 0);
            end
        end

        // R9: a push restarts the tick count
        set_sel(2);
        do_clr();
        do_push(8'h21); do_push(8'h22);
        for (int k = 0; k < 3; k++) step(0, 8'h00, 0, 1, 0, 0);
        do_push(8'h23);
        chk("R9", "irq_tmo after push", int'(irq_tmo), 0);
        for (int k = 1; k <= 4; k++) begin
            step(0, 8'h00, 0, 1, 0, 0);
            chk("R9", "irq_tmo restarted", int'(irq_tmo), int'(k == 4));
        end
        do_pop();
        chk("R9", "irq_tmo cleared", int'(irq_tmo), 0);
        step(0, 8'h00, 0, 0, 0, 0);
        for (int k = 1; k <= 4; k++) begin
            step(0, 8'h00, 0, 1, 0, 0);
            chk("R9", "irq_tmo after pop restart", int'(irq_tmo), int'(k == 4));
        end

        // R4: single holding register mode
        set_mode(0);
        chk_all("R4");
        do_push(8'h3C);
        chk_all("R4");
        do_push(8'hC3);
        chk_all("R4");
        chk("R4", "host_byte", int'(host_byte), 8'h3C);
        for (int k = 0; k < 5; k++) step(0, 8'h00, 0, 1, 0, 0);
        chk("R4", "irq_tmo", int'(irq_tmo), 0);
        do_pop();
        chk_all("R4");
        step(0, 8'h00, 0, 0, 0, 1);
        movr = 0;
        chk("R4", "overrun ack", int'(overrun), 0);
        do_push(8'h77);
        set_mode(1);
        chk_all("R4");

        // R1: clear in the middle of a fill
        set_sel(3);
        for (int i = 0; i < 15; i++) do_push(8'(i));
        chk_all("R6");
        do_push(8'h01); do_push(8'h02);
        chk("R3", "overrun", int'(overrun), 1);
        do_clr();
        chk_all("R1");
        chk("R1", "irq_tmo", int'(irq_tmo), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule